// File: doc/BRIEF.md
# GPIO Controller with Edge-Cause Interrupts

This block is a register-mapped general purpose I/O controller for up to 32 pins per instance. It sits behind a simple 32-bit register bus. A two-bit window select picks one of four register windows, and a byte offset picks a register inside the window. Output enable and output data are never written directly. One window sets their bits when a 1 is written, and another window clears their bits when a 1 is written. This lets software change a single pin without a read-modify-write sequence. The same 32-bit layout also serves a reduced configuration, for example 24 pins, in which the unused upper bits are tied off.

Incoming pin levels pass through a two-flop synchronizer. The synchronized value is compared with its value one cycle earlier to find rising and falling edges. A per-pin rising-enable mask and falling-enable mask decide which edges set a sticky cause bit. An event-enable mask then selects which cause bits may reach a single interrupt line. That line is an OR of the enabled causes, so it can be shared with other sources. Software clears cause bits by writing 1s to a clear register.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero (all pins are inputs), and `irq` is low.
- R2: Window 2 is the set window. A write to offset 0x00 ORs the write data into output enable, and a write to offset 0x04 ORs it into output data. Zero bits leave a bit unchanged. Reads at these offsets return the current register. Without a write to window 2 or window 3, `pin_oe` and `pin_out` hold.
- R3: Window 3 is the clear window. A write to offset 0x00 clears the output-enable bits written as 1, and a write to offset 0x04 clears the output-data bits written as 1. Reads at these offsets return the same registers as in window 2.
- R4: Bits at or above NUM_PINS read as zero in every register, ignore writes, and stay zero on `pin_oe` and `pin_out`.
- R5: Window 0, offset 0x08 returns the synchronized pin levels. A pin change becomes visible to a read captured on the third rising clock edge after the change, and not earlier. Writes to this offset are ignored.
- R6: Window 0, offset 0x00 is the read/write rising-edge enable, and offset 0x04 is the read/write falling-edge enable. An enabled edge sets the pin's cause bit. When both enables are set, either edge sets it. An edge whose enable is clear sets nothing.
- R7: Cause bits are sticky. They are set whatever the event-enable value is. Window 1, offset 0x00 returns cause AND event-enable. Window 1, offset 0x14 is the read/write event-enable register.
- R8: Writing 1s to window 1, offset 0x18 clears the matching cause bits. Writing all ones clears every cause. Zero bits keep their causes.
- R9: `irq` is high exactly when some cause bit is set together with its event-enable bit. It stays high until those causes are cleared or masked.
- R10: When an edge sets a cause bit on the same clock edge as a write that clears that bit, the bit ends up set.
- R11: Read data appears on `bus_rdata` in the cycle after the read is captured. Unused offsets, and the cause-clear offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_win | input | 2 | Window select: 0 main, 1 cause, 2 set, 3 clear |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_oe | output | 32 | Output enable per pin |
| pin_out | output | 32 | Output data per pin |
| irq | output | 1 | Shared interrupt, OR of enabled cause bits |

## Verification
Register writes take effect on the capturing edge. `pin_oe`, `pin_out` and `irq` are therefore checked at the falling edge that follows that capture. Each read pushes its expected word into a queue. A monitor pops that word and compares it with `bus_rdata` just after the edge that captured the read, which is the one-cycle read latency. A pin change needs three edges before it reaches the cause bits and `irq`: two synchronizer stages and then the cause register. The bench waits four cycles before it checks those results. It also reads the data-in register on the first, second and third edges after a change, to pin down exactly when the change becomes visible. The collision case places the clear write on exactly the third edge after a pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    WIN_MAIN  = 2'd0,
    WIN_CAUSE = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } win_e;

  // main window
  localparam logic [ADDR_W-1:0] OFS_RISE_EN   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LEVEL     = 5'h08;
  // cause window
  localparam logic [ADDR_W-1:0] OFS_MASKED    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN    = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_CAUSE_CLR = 5'h18;
  // set and clear windows
  localparam logic [ADDR_W-1:0] OFS_OE        = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT      = 5'h04;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign level[i] = sync_q;
    assign rise[i]  = sync_q & ~prev_q;
    assign fall[i]  = ~sync_q & prev_q;
  end

endmodule

// File: rtl/gpio_edge_outregs.sv
module gpio_edge_outregs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_set_we,
  input  logic         oe_clr_we,
  input  logic         dout_set_we,
  input  logic         dout_clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] oe,
  output logic [N-1:0] dout
);

  logic [N-1:0] oe_q, oe_d, dout_q, dout_d;
  logic         oe_en, dout_en;

  always_comb begin
    oe_en   = oe_set_we | oe_clr_we;
    dout_en = dout_set_we | dout_clr_we;
    oe_d    = oe_q;
    dout_d  = dout_q;
    if (oe_set_we)   oe_d   = oe_q | wdata;
    if (oe_clr_we)   oe_d   = oe_q & ~wdata;
    if (dout_set_we) dout_d = dout_q | wdata;
    if (dout_clr_we) dout_d = dout_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      dout_q <= '0;
    end else begin
      if (oe_en)   oe_q   <= oe_d;
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign oe   = oe_q;
  assign dout = dout_q;

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_we,
  input  logic         fall_we,
  input  logic         evt_we,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] rise_evt,
  input  logic [N-1:0] fall_evt,
  output logic [N-1:0] rise_en,
  output logic [N-1:0] fall_en,
  output logic [N-1:0] evt_en,
  output logic [N-1:0] cause,
  output logic         irq
);

  logic [N-1:0] rise_q, fall_q, evt_q, cause_q;
  logic [N-1:0] cause_d, hit, clr_mask;

  always_comb begin
    hit      = (rise_evt & rise_q) | (fall_evt & fall_q);
    clr_mask = clr_we ? wdata : '0;
    // a fresh edge outranks a clear of the same bit
    cause_d  = (cause_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      evt_q   <= '0;
      cause_q <= '0;
    end else begin
      if (rise_we) rise_q <= wdata;
      if (fall_we) fall_q <= wdata;
      if (evt_we)  evt_q  <= wdata;
      cause_q <= cause_d;
    end
  end

  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign evt_en  = evt_q;
  assign cause   = cause_q;
  assign irq     = |(cause_q & evt_q);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_win,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_oe,
  output logic [31:0] pin_out,
  output logic        irq
);

  localparam int N = NUM_PINS;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // access decode
  logic wr, rd;
  logic in_main, in_cause, in_set, in_clr;
  assign wr       = bus_en & bus_we;
  assign rd       = bus_en & ~bus_we;
  assign in_main  = bus_win == WIN_MAIN;
  assign in_cause = bus_win == WIN_CAUSE;
  assign in_set   = bus_win == WIN_SET;
  assign in_clr   = bus_win == WIN_CLR;

  logic oe_set_we, oe_clr_we, dout_set_we, dout_clr_we;
  logic rise_we, fall_we, evt_we, clr_we;
  assign oe_set_we   = wr & in_set   & (bus_addr == OFS_OE);
  assign dout_set_we = wr & in_set   & (bus_addr == OFS_DOUT);
  assign oe_clr_we   = wr & in_clr   & (bus_addr == OFS_OE);
  assign dout_clr_we = wr & in_clr   & (bus_addr == OFS_DOUT);
  assign rise_we     = wr & in_main  & (bus_addr == OFS_RISE_EN);
  assign fall_we     = wr & in_main  & (bus_addr == OFS_FALL_EN);
  assign evt_we      = wr & in_cause & (bus_addr == OFS_EVT_EN);
  assign clr_we      = wr & in_cause & (bus_addr == OFS_CAUSE_CLR);

  logic [N-1:0] wdata_n;
  assign wdata_n = bus_wdata[N-1:0];

  logic [N-1:0] level, rise_evt, fall_evt;
  logic [N-1:0] oe, dout, rise_en, fall_en, evt_en, cause;

  gpio_edge_sync #(.N(N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in[N-1:0]),
    .level  (level),
    .rise   (rise_evt),
    .fall   (fall_evt)
  );

  gpio_edge_outregs #(.N(N)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .oe_set_we   (oe_set_we),
    .oe_clr_we   (oe_clr_we),
    .dout_set_we (dout_set_we),
    .dout_clr_we (dout_clr_we),
    .wdata       (wdata_n),
    .oe          (oe),
    .dout        (dout)
  );

  gpio_edge_cause #(.N(N)) u_cause (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rise_we  (rise_we),
    .fall_we  (fall_we),
    .evt_we   (evt_we),
    .clr_we   (clr_we),
    .wdata    (wdata_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .evt_en   (evt_en),
    .cause    (cause),
    .irq      (irq)
  );

  // widen N-bit fields to the 32-bit bus, upper bits tied to zero
  logic [31:0] oe_w, dout_w, rise_w, fall_w, evt_w, masked_w, level_w;
  always_comb begin
    oe_w     = '0; oe_w[N-1:0]     = oe;
    dout_w   = '0; dout_w[N-1:0]   = dout;
    rise_w   = '0; rise_w[N-1:0]   = rise_en;
    fall_w   = '0; fall_w[N-1:0]   = fall_en;
    evt_w    = '0; evt_w[N-1:0]    = evt_en;
    masked_w = '0; masked_w[N-1:0] = cause & evt_en;
    level_w  = '0; level_w[N-1:0]  = level;
  end

  // read path
  logic [31:0] rdata_d, rdata_q;
  always_comb begin
    rdata_d = '0;
    unique case (bus_win)
      WIN_MAIN: begin
        if (bus_addr == OFS_RISE_EN) rdata_d = rise_w;
        if (bus_addr == OFS_FALL_EN) rdata_d = fall_w;
        if (bus_addr == OFS_LEVEL)   rdata_d = level_w;
      end
      WIN_CAUSE: begin
        if (bus_addr == OFS_MASKED) rdata_d = masked_w;
        if (bus_addr == OFS_EVT_EN) rdata_d = evt_w;
      end
      default: begin
        if (bus_addr == OFS_OE)   rdata_d = oe_w;
        if (bus_addr == OFS_DOUT) rdata_d = dout_w;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd)     rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign pin_oe    = oe_w;
  assign pin_out   = dout_w;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic        clk,
  input logic        rst_ok,
  input logic        bus_en,
  input logic        bus_we,
  input logic [1:0]  bus_win,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] pin_oe,
  input logic [31:0] pin_out,
  input logic        irq
);

  localparam logic [31:0] MASK = 32'hFFFF_FFFF >> (32 - NUM_PINS);

  logic oe_set_w, oe_clr_w, outwin_w, cause_w;
  assign oe_set_w = bus_en && bus_we && bus_win == 2'd2 && bus_addr == 5'h00;
  assign oe_clr_w = bus_en && bus_we && bus_win == 2'd3 && bus_addr == 5'h00;
  assign outwin_w = bus_en && bus_we && (bus_win == 2'd2 || bus_win == 2'd3);
  assign cause_w  = bus_en && bus_we && bus_win == 2'd1;

  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    oe_set_w |=> pin_oe == ($past(pin_oe) | ($past(bus_wdata) & MASK)));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !outwin_w |=> ($stable(pin_oe) && $stable(pin_out)));

  p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    oe_clr_w |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

  p_tieoff_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    ((pin_oe & ~MASK) == 32'd0) && ((pin_out & ~MASK) == 32'd0));

  p_irq_held_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq && !cause_w) |=> irq);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_win   (bus_win),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .irq       (irq)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/100ps
module gpio_edge_ctrl_test;

  localparam int PINS = 24;
  localparam logic [31:0] M = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_win = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_oe, pin_out;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(PINS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // drivers: called at a falling edge, return at the next falling edge
  task automatic wr(logic [1:0] w, logic [4:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_win = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] w, logic [4:0] a, logic [31:0] exp, string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_win = w; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: data of a read is on bus_rdata just after its capture edge
  initial begin
    forever begin
      @(posedge clk);
      begin
        automatic logic was_rd = bus_en && !bus_we;
        #1;
        if (was_rd) begin
          if (exp_q.size() == 0) check("monitor: read with no expectation", bus_rdata, 32'hx);
          else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // reset state
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(2'd0, 5'h00, 0, "R1 rise enable");
    rd(2'd0, 5'h04, 0, "R1 fall enable");
    rd(2'd1, 5'h14, 0, "R1 event enable");
    rd(2'd2, 5'h00, 0, "R1 output enable");

    // set window
    wr(2'd2, 5'h00, 32'hFFFF_00F0);
    check("R2 R4 oe set with upper bits", pin_oe, 32'h00FF_00F0);
    wr(2'd2, 5'h04, 32'h0000_0F0F);
    check("R2 dout set", pin_out, 32'h0000_0F0F);
    wr(2'd2, 5'h00, 32'h0000_0001);
    check("R2 zeros keep bits", pin_oe, 32'h00FF_00F1);
    rd(2'd2, 5'h00, 32'h00FF_00F1, "R2 R4 oe readback");

    // clear window
    wr(2'd3, 5'h00, 32'h000F_0000);
    check("R3 oe clear", pin_oe, 32'h00F0_00F1);
    wr(2'd3, 5'h04, 32'h0000_0003);
    check("R3 dout clear", pin_out, 32'h0000_0F0C);
    rd(2'd3, 5'h04, 32'h0000_0F0C, "R3 dout readback in clear window");

    // data-in timing: visible on the third capture edge
    pin_in = 32'hA5C3_5A96;
    rd(2'd0, 5'h08, 0, "R5 level first edge");
    rd(2'd0, 5'h08, 0, "R5 level second edge");
    rd(2'd0, 5'h08, 32'hA5C3_5A96 & M, "R5 R4 level third edge");
    pin_in = 0;
    idle(4);

    // edge enables: bit0 rise, bit1 fall, bit2 both
    wr(2'd0, 5'h00, 32'h5);
    wr(2'd0, 5'h04, 32'h6);
    pin_in = 32'h7;
    idle(4);
    rd(2'd1, 5'h00, 0, "R7 masked read with event enable zero");
    idle(1);
    check("R9 irq masked", {31'd0, irq}, 0);
    wr(2'd1, 5'h14, 32'hFFFF_FFFF);
    rd(2'd1, 5'h14, M, "R7 R4 event enable readback");
    rd(2'd1, 5'h00, 32'h5, "R6 rising edges");
    check("R9 irq on", {31'd0, irq}, 1);
    pin_in = 0;
    idle(4);
    rd(2'd1, 5'h00, 32'h7, "R6 falling edge adds bit1");
    idle(3);
    rd(2'd1, 5'h00, 32'h7, "R7 causes sticky");

    // masking and clearing
    wr(2'd1, 5'h14, 32'h2);
    rd(2'd1, 5'h00, 32'h2, "R7 mask applied");
    wr(2'd1, 5'h18, 32'h2);
    rd(2'd1, 5'h00, 0, "R8 single clear");
    check("R9 irq off when enabled causes gone", {31'd0, irq}, 0);
    wr(2'd1, 5'h14, M);
    rd(2'd1, 5'h00, 32'h5, "R8 R7 other causes kept");
    check("R9 irq back", {31'd0, irq}, 1);
    wr(2'd1, 5'h18, 32'hFFFF_FFFF);
    rd(2'd1, 5'h00, 0, "R8 clear all");
    check("R8 irq after clear all", {31'd0, irq}, 0);

    // edge coinciding with clear
    pin_in = 32'h1;
    idle(4);
    pin_in = 32'h5;
    idle(2);
    wr(2'd1, 5'h18, 32'h5);
    rd(2'd1, 5'h00, 32'h4, "R10 edge beats clear");
    check("R10 irq", {31'd0, irq}, 1);
    wr(2'd1, 5'h18, 32'h4);
    rd(2'd1, 5'h00, 0, "R10 later clear works");

    // unused offsets, read-only level, tie-off on a mask
    rd(2'd0, 5'h0C, 0, "R11 unused offset");
    rd(2'd1, 5'h18, 0, "R11 clear offset reads zero");
    wr(2'd0, 5'h08, 32'hFFFF_FFFF);
    rd(2'd0, 5'h08, 32'h5, "R5 level ignores writes");
    wr(2'd0, 5'h00, 32'hFFFF_FFFF);
    rd(2'd0, 5'h00, M, "R4 rise enable upper bits");

    idle(3);
    if (exp_q.size() != 0) check("monitor: pending reads", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule